// File: doc/BRIEF.md
# Dual-Width Transmit Byte Queue

This block is the transmit staging queue of a two-wire serial controller. It sits on a 32-bit peripheral write bus and offers two write-only data ports. A write to the narrow port queues one byte. A write to the wide port queues two bytes in a single bus access. On the other side, a byte-wide valid/ready stream feeds the serial shifter, oldest byte first.

The queue is shallow, with two bytes by default. When a write arrives that the queue cannot take, the block does not drop it and does not raise an error. It holds the bus with a wait signal until enough entries are free, and the write then completes. A 2-bit occupancy code is always visible to software. A service-request line stays high while the queue is empty, to ask for more transmit data.

Top module: `txq_dual_width`

## Requirements
- R1: Bytes leave the drain port in exactly the order in which they were queued, across any mix of narrow and wide writes.
- R2: A completed write with `bus_port`=0 (narrow) queues exactly one byte, taken from `bus_wdata[7:0]`. Bits [31:8] have no effect.
- R3: A completed write with `bus_port`=1 (wide) queues exactly two bytes. Bits [7:0] go in first and bits [15:8] second. Bits [31:16] have no effect.
- R4: A narrow write while the queue is full raises `bus_wait` in every cycle until an entry is free. The write then completes and no byte is lost.
- R5: A wide write raises `bus_wait` until the queue is completely empty. The write then completes with both bytes.
- R6: `status` gives the occupancy in the cycle after each access: 2'b00 means empty, 2'b01 means one byte held, 2'b11 means full (DEPTH bytes). The value 2'b10 is never produced.
- R7: A read access (`bus_we`=0) returns `bus_rdata`=0, never raises `bus_wait` and leaves the occupancy unchanged.
- R8: `drain_valid` is high exactly while the queue holds a byte, and `drain_data` is then the oldest byte. One byte is removed at each clock edge where `drain_valid` and `drain_ready` are both high.
- R9: `svc_req` is high exactly while the queue is empty.
- R10: While `rst_n` is low at a clock edge, the queue is emptied and `status` becomes 2'b00. A write that is being held in a wait state is released, so `bus_wait` drops in the following cycle.
- R11: Free space is judged on the occupancy at the start of the cycle. A byte drained in the same cycle lets a stalled write complete only from the next cycle, so a write stalled on a full queue waits exactly one cycle longer than the cycle of the first drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access to a data port in this cycle; held stable while `bus_wait` is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | 0 = narrow (one byte), 1 = wide (two bytes) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, always zero |
| bus_wait | output | 1 | Holds the current write until room is available |
| status | output | 2 | Occupancy code |
| svc_req | output | 1 | High while the queue is empty |
| drain_valid | output | 1 | Head byte present |
| drain_data | output | BYTE_W | Head byte |
| drain_ready | input | 1 | Shifter accepts the head byte |

## Verification
A corrupted pointer or occupancy count in this block shows at the ports within one or two cycles. The status code or `svc_req` disagrees with the number of bytes the bench has queued and not yet drained. A wrong write or read pointer shows at the scoreboard on the next drain, as a byte out of order or a missing byte. A wrong room calculation shows as a wait-cycle count on a stalled write that differs from the exact value the bench predicts, or as a wide write that completes while a byte is still held.

// File: rtl/txq_pkg.sv
// Package: shared port selector type and occupancy encoding for the
// dual-width transmit queue. Assumes occupancy counts never exceed depth.
package txq_pkg;

    typedef enum logic {
        PORT_NARROW = 1'b0,
        PORT_WIDE   = 1'b1
    } txq_port_e;

    localparam logic [1:0] ST_EMPTY = 2'b00;
    localparam logic [1:0] ST_SOME  = 2'b01;
    localparam logic [1:0] ST_FULL  = 2'b11;

    // Bytes a write to the given port adds to the queue.
    function automatic int unsigned bytes_for(input txq_port_e p);
        return (p == PORT_WIDE) ? 2 : 1;
    endfunction

endpackage

// File: rtl/txq_bus_if.sv
// Module: txq_bus_if
// Decodes a data-port access against the current occupancy. It decides
// whether a write completes this cycle (and how many bytes it pushes) or is
// held with a wait state. Room is judged on the occupancy at the start of the
// cycle, with no drain bypass. Assumes DEPTH >= 2 so that a wide write can fit.
module txq_bus_if #(
    parameter int BUS_W  = 32,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              req_i,
    input  logic              we_i,
    input  txq_pkg::txq_port_e port_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              wait_o,
    output logic [1:0]        push_n_o,
    output logic [BYTE_W-1:0] push_b0_o,
    output logic [BYTE_W-1:0] push_b1_o,
    output logic [BUS_W-1:0]  rdata_o
);
    import txq_pkg::*;

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_s;
    logic [CNT_W-1:0] need_s;
    logic             fits_s;
    logic             wr_s;

    // Free entries and the entries this access needs.
    always_comb begin
        free_s = DEPTH_C - count_i;
        need_s = CNT_W'(bytes_for(port_i));
        fits_s = (free_s >= need_s);
        wr_s   = req_i && we_i;
    end

    // Hold or complete the write; pick the bytes from the low lanes.
    always_comb begin
        wait_o    = wr_s && !fits_s;
        push_n_o  = 2'd0;
        if (wr_s && fits_s) begin
            push_n_o = (port_i == PORT_WIDE) ? 2'd2 : 2'd1;
        end
        push_b0_o = wdata_i[BYTE_W-1:0];
        push_b1_o = wdata_i[2*BYTE_W-1:BYTE_W];
    end

    // Data ports are write-only: reads see zero.
    assign rdata_o = '0;

endmodule

// File: rtl/txq_store.sv
// Module: txq_store
// Circular byte storage of DEPTH entries. It accepts zero, one or two bytes per
// cycle (b0 lands before b1) and drains at most one byte per cycle. The caller
// guarantees that a push never exceeds the free room at the start of the cycle.
module txq_store #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        push_n_i,
    input  logic [BYTE_W-1:0] push_b0_i,
    input  logic [BYTE_W-1:0] push_b1_i,
    input  logic              pop_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [BYTE_W-1:0] head_o
);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

    // Next entry index with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, wr_ptr_p1;
    logic [CNT_W-1:0]  count_q;
    logic [BYTE_W-1:0] entry_q [DEPTH];
    logic              do_pop;

    assign wr_ptr_p1 = step(wr_ptr_q);
    assign do_pop    = pop_i && (count_q != '0);

    // Per-entry write: first byte at wr_ptr, second byte one further on.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        logic we0, we1;
        assign we0 = (push_n_i != 2'd0) && (wr_ptr_q == PTR_W'(gi));
        assign we1 = (push_n_i == 2'd2) && (wr_ptr_p1 == PTR_W'(gi));
        // Load the entry from whichever push lane targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[gi] <= '0;
            end else if (we0) begin
                entry_q[gi] <= push_b0_i;
            end else if (we1) begin
                entry_q[gi] <= push_b1_i;
            end
        end
    end

    // Advance the write pointer by the number of bytes pushed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (push_n_i == 2'd1) begin
            wr_ptr_q <= wr_ptr_p1;
        end else if (push_n_i == 2'd2) begin
            wr_ptr_q <= step(wr_ptr_p1);
        end
    end

    // Advance the read pointer on each drained byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
        end else if (do_pop) begin
            rd_ptr_q <= step(rd_ptr_q);
        end
    end

    // Track occupancy: add pushes, remove the drained byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + CNT_W'(push_n_i) - CNT_W'(do_pop);
        end
    end

    assign count_o = count_q;
    assign head_o  = entry_q[rd_ptr_q];

endmodule

// File: rtl/txq_status.sv
// Module: txq_status
// Turns the occupancy count into the status code, the drain-valid flag and
// the service request. Assumes count never exceeds DEPTH.
module txq_status #(
    parameter int DEPTH  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [1:0]       status_o,
    output logic             nonempty_o,
    output logic             svc_o
);
    import txq_pkg::*;

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    // Encode occupancy: empty, partly filled, full.
    always_comb begin
        if (count_i == '0) begin
            status_o = ST_EMPTY;
        end else if (count_i >= DEPTH_C) begin
            status_o = ST_FULL;
        end else begin
            status_o = ST_SOME;
        end
        nonempty_o = (count_i != '0);
        svc_o      = (count_i == '0);
    end

endmodule

// File: rtl/txq_dual_width.sv
// Module: txq_dual_width (top)
// Transmit byte queue with a narrow (1 byte) and a wide (2 byte) write-only
// data port on a peripheral bus, wait-state flow control and a byte drain
// stream. Assumes the bus master holds an access stable while bus_wait is high.
module txq_dual_width #(
    parameter int BUS_W  = 32,
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_port,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_wait,
    output logic [1:0]        status,
    output logic              svc_req,
    output logic              drain_valid,
    output logic [BYTE_W-1:0] drain_data,
    input  logic              drain_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  count_s;
    logic [1:0]        push_n_s;
    logic [BYTE_W-1:0] push_b0_s, push_b1_s;
    logic              nonempty_s;

    txq_bus_if #(.BUS_W(BUS_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_bus (
        .req_i    (bus_req),
        .we_i     (bus_we),
        .port_i   (txq_pkg::txq_port_e'(bus_port)),
        .wdata_i  (bus_wdata),
        .count_i  (count_s),
        .wait_o   (bus_wait),
        .push_n_o (push_n_s),
        .push_b0_o(push_b0_s),
        .push_b1_o(push_b1_s),
        .rdata_o  (bus_rdata)
    );

    txq_store #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_n_i (push_n_s),
        .push_b0_i(push_b0_s),
        .push_b1_i(push_b1_s),
        .pop_i    (drain_ready),
        .count_o  (count_s),
        .head_o   (drain_data)
    );

    txq_status #(.DEPTH(DEPTH)) u_stat (
        .count_i   (count_s),
        .status_o  (status),
        .nonempty_o(nonempty_s),
        .svc_o     (svc_req)
    );

    assign drain_valid = nonempty_s;

endmodule

// File: rtl/txq_dual_width_chk.sv
// Module: txq_dual_width_chk
// Port-level properties of the transmit queue, attached by bind.
module txq_dual_width_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic             bus_port,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             bus_wait,
    input logic [1:0]       status,
    input logic             svc_req,
    input logic             drain_valid,
    input logic             drain_ready
);
    logic wr_done;
    assign wr_done = bus_req && bus_we && !bus_wait;

    // R6
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b10);

    // R7
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_rdata == '0 && !bus_wait));

    // R4
    narrow_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wait && !bus_port) |-> (status == 2'b11));

    // R5
    wide_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wait && bus_port) |-> (status != 2'b00));

    // R9
    svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req == (status == 2'b00));

    // R8
    valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid == (status != 2'b00));

    // R8
    pop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01 && drain_ready && !wr_done) |=> (status == 2'b00));

    // R2
    narrow_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00 && wr_done && !bus_port) |=> (status == 2'b01));

    // R10
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> (status == 2'b00 && !bus_wait));

endmodule

bind txq_dual_width txq_dual_width_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_port   (bus_port),
    .bus_rdata  (bus_rdata),
    .bus_wait   (bus_wait),
    .status     (status),
    .svc_req    (svc_req),
    .drain_valid(drain_valid),
    .drain_ready(drain_ready)
);

// File: tb/txq_dual_width_bench.sv
// Scoreboard bench: bus_write queues the expected bytes, the monitor checks the drain.
module txq_dual_width_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_port = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_wait;
    logic [1:0]  status;
    logic        svc_req, drain_valid, drain_ready = 1'b0;
    logic [7:0]  drain_data;

    int checks = 0, fails = 0;
    logic [7:0] expq[$];
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    txq_dual_width u_txq_dual_width (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .status(status), .svc_req(svc_req),
        .drain_valid(drain_valid), .drain_data(drain_data),
        .drain_ready(drain_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: one bus write, held while bus_wait is high; returns stall cycles.
    task automatic bus_write(input bit port, input logic [31:0] d, output int waited);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_port = port; bus_wdata = d; waited = 0;
        forever begin
            #1;
            if (!bus_wait) break;
            waited++;
            @(negedge clk);
        end
        @(posedge clk);
        expq.push_back(d[7:0]);
        if (port) expq.push_back(d[15:8]);
        #1 bus_req = 0; bus_we = 0;
    endtask

    task automatic check_status(input logic [1:0] exp, input string req);
        @(negedge clk); #3;
        check(status == exp, req, status, exp);
        check(svc_req == (exp == 2'b00), "R9", svc_req, exp == 2'b00);
    endtask

    task automatic drain_all;
        @(negedge clk); drain_ready = 1;
        repeat (6) @(negedge clk);
        drain_ready = 0;
        check(expq.size() == 0, "R1", expq.size(), 0);
    endtask

    // Monitor: compare each drained byte against the scoreboard head.
    always begin
        @(negedge clk); #2;
        if (rst_n && drain_valid && drain_ready) begin
            if (expq.size() == 0) begin
                check(0, "R1", drain_data, 0);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                check(drain_data == e, "R1/R8", drain_data, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        #3;
        check(status == 2'b00, "R10", status, 0);
        check(!drain_valid && !bus_wait, "R10", {drain_valid, bus_wait}, 0);
        check(svc_req, "R9", svc_req, 1);

        // R2 narrow port, upper bits ignored
        bus_write(0, 32'hDEADBE77, w);
        check_status(2'b01, "R6");
        check(drain_valid && drain_data == 8'h77, "R2", drain_data, 8'h77);
        bus_write(0, 32'hFFFFFF5A, w);
        check_status(2'b11, "R6");

        // R7 read returns zero, no stall, no change
        @(negedge clk); bus_req = 1; bus_we = 0; bus_port = 1; #1;
        check(bus_rdata == 0 && !bus_wait, "R7", bus_rdata, 0);
        @(posedge clk); #1 bus_req = 0;
        check_status(2'b11, "R7");

        // R4/R11 narrow write stalled on full queue
        fork
            bus_write(0, 32'h000000C3, w);
            begin repeat (5) @(negedge clk); drain_ready = 1; end
        join
        check(w == 5, "R4/R11", w, 5);
        drain_ready = 0;
        drain_all();

        // R3 wide port, low byte first
        bus_write(1, 32'hFFFF1234, w);
        check(w == 0, "R3", w, 0);
        check_status(2'b11, "R3");
        check(drain_data == 8'h34, "R3", drain_data, 8'h34);
        drain_all();

        // R5 wide write waits for a completely empty queue
        bus_write(0, 32'h11, w);
        fork
            bus_write(1, 32'h0000ABCD, w);
            begin repeat (5) @(negedge clk); drain_ready = 1; end
        join
        check(w == 5, "R5", w, 5);
        drain_ready = 0;
        drain_all();

        // R1 streaming mix with drain always ready
        @(negedge clk); drain_ready = 1;
        for (int i = 0; i < 12; i++) begin
            bus_write(i[0], 32'h0000_3000 + 32'(i * 7), w);
        end
        repeat (6) @(negedge clk);
        drain_ready = 0;
        check(expq.size() == 0, "R1", expq.size(), 0);
        check_status(2'b00, "R6");

        // R10 reset releases a held write
        bus_write(0, 32'h21, w);
        bus_write(0, 32'h22, w);
        @(negedge clk); bus_req = 1; bus_we = 1; bus_port = 0; bus_wdata = 32'h23; #1;
        check(bus_wait, "R10", bus_wait, 1);
        rst_n = 0;
        @(posedge clk); #1;
        bus_req = 0; bus_we = 0;
        expq.delete();
        check(status == 2'b00 && !bus_wait && !drain_valid, "R10",
              {status, bus_wait, drain_valid}, 0);
        @(negedge clk); rst_n = 1;
        check_status(2'b00, "R10");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule